// File: doc/BRIEF.md
# Split Dual-Channel DMA FIFO

This block holds one shared data buffer of 16 words, each 32 bits wide, for two disk channels. A configuration byte decides how the words are divided. All of them can go to the primary channel, all of them to the secondary channel, or each channel can get half. Each channel's share then behaves as its own first-in first-out queue, with its own pointers, fill level and DMA request. The request rises once the fill level reaches a threshold. The threshold is a coded fraction of that channel's share.

A channel whose share is empty reports that DMA is refused and never requests. Its drive can still be reached by non-DMA access, which does not pass through this block. A default layout can be loaded instead of an explicit byte. That layout depends on which channels are enabled.

Each partition can be emptied at once in three ways: by a flush pin, by an interrupt when interrupt flushing is enabled, or at the end of a 512-byte sector when sector flushing is enabled. The write and read ports follow valid/ready rules:
- A word moves in when `wr_valid` and `wr_ready` are both high.
- `wr_valid` while `wr_ready` is low drops the word and flags overflow.
- `rd_data` shows the head word whenever `rd_valid` is high.
- `rd_ready` pops that word.
- `rd_ready` while `rd_valid` is low returns zero and flags underflow.

The configuration port has `cfg_ready` high only while both partitions are empty.

Top module: `split_fifo_dual`

## Requirements
- R1: Configuration bits [6:5] set the split. 00 gives 16 words to the primary channel (channel 0), 11 gives 16 words to the secondary channel (channel 1), and 01 or 10 give 8 words to each. A channel's level saturates at its share, and `wr_ready` is high exactly while its level is below its share.
- R2: The primary threshold code is bits [3:2] and the secondary code is bits [1:0]. Code 00 means the full share, 01 means 3/4, 10 means 1/2 and 11 means 1/4. The threshold is rounded down but is never below 1 word. `dma_req` is high while the level is at or above the threshold.
- R3: A channel with a zero share holds `dma_off` high, keeps `dma_req`, `wr_ready` and `rd_valid` low, and always reads zero.
- R4: At reset, and when a configuration is applied with `cfg_dflt` high, the layout comes from `ch_en`:
  - primary only (01) selects split 00;
  - secondary only (10) selects split 11;
  - both or neither selects split 01.
  In every case both threshold codes become 01, and bits 7 and 4 keep their previous values (zero at reset).
- R5: Bits 7 and 4 of an applied byte appear unchanged on `cfg_q` and have no effect on the split.
- R6: A configuration is taken only when both partitions are empty (`cfg_ready` high). Taking it empties both partitions and clears the sticky overflow and underflow flags.
- R7: Within a partition, words leave in the order they entered. Traffic on one channel does not change the other channel's data or level.
- R8: A write to a full partition, or to a zero share, is dropped and sets that channel's sticky `ovf`.
- R9: A read from an empty partition returns zero on `rd_data` and sets that channel's sticky `udf`.
- R10: A one-cycle pulse on `flush[c]` leaves partition c empty after the next clock edge.
- R11: `irq[c]` empties partition c on the next edge only while `irq_flush_en[c]` is high. Otherwise it has no effect.
- R12: With `sec_flush_en[c]` high, partition c is emptied on the edge after its 128th accepted word since the last configuration. With it low, no such flush happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ch_en | input | 2 | Enabled channels, used for the default layout |
| cfg_valid | input | 1 | Configuration request |
| cfg_dflt | input | 1 | Use the default layout instead of cfg_byte |
| cfg_byte | input | 8 | Requested configuration byte |
| cfg_ready | output | 1 | High while both partitions are empty |
| cfg_q | output | 8 | Configuration in force |
| wr_valid | input | 2 | Per-channel write valid |
| wr_data | input | 64 | Per-channel write word (channel c at [32c+31:32c]) |
| wr_ready | output | 2 | Per-channel write ready |
| rd_valid | output | 2 | Per-channel head word present |
| rd_ready | input | 2 | Per-channel pop request |
| rd_data | output | 64 | Per-channel head word, zero when empty |
| level | output | 10 | Per-channel fill level (5 bits each) |
| dma_req | output | 2 | Per-channel DMA request |
| dma_off | output | 2 | Per-channel DMA refused (zero share) |
| flush | input | 2 | Per-channel flush pulse |
| irq | input | 2 | Per-channel interrupt |
| irq_flush_en | input | 2 | Flush on interrupt enable |
| sec_flush_en | input | 2 | Flush at sector end enable |
| ovf | output | 2 | Sticky overflow |
| udf | output | 2 | Sticky underflow |

## Verification
The sector-end flush is the case hardest to reach from the ports. It needs 128 accepted words while a partition holds at most 16. The stimulus therefore alternates one push with one pop 127 times, pushes a 128th word, and checks that the level is one and then falls to zero one edge later. The same sequence is run once with the enable low, where the word must stay.

The split and threshold behaviour is swept over every configuration byte pattern. Each pattern is filled past full on both channels at once and then drained past empty.

// File: rtl/split_fifo_pkg.sv
package split_fifo_pkg;

  typedef struct packed {
    logic       keep7;
    logic [1:0] split;
    logic       keep4;
    logic [1:0] thr0;
    logic [1:0] thr1;
  } cfg_t;

  // Threshold in words: share * (4 - code) / 4, floor, at least 1.
  function automatic int unsigned thr_words(int unsigned share, logic [1:0] code);
    int unsigned t;
    t = (share * (32'd4 - 32'(code))) / 32'd4;
    if (t == 0) t = 1;
    return t;
  endfunction

  function automatic cfg_t dflt_cfg(cfg_t cur, logic [1:0] en);
    cfg_t d;
    d      = cur;
    d.thr0 = 2'b01;
    d.thr1 = 2'b01;
    case (en)
      2'b01:   d.split = 2'b00;
      2'b10:   d.split = 2'b11;
      default: d.split = 2'b01;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/split_fifo_cfg.sv
module split_fifo_cfg
  import split_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    ch_en,
  input  logic          cfg_valid,
  input  logic          cfg_dflt,
  input  logic [7:0]    cfg_byte,
  input  logic          both_empty,
  output logic          cfg_ready,
  output logic          apply,
  output cfg_t          cfg_q,
  output logic [LW-1:0] share0,
  output logic [LW-1:0] share1,
  output logic [LW-1:0] thr0,
  output logic [LW-1:0] thr1
);

  cfg_t nxt;

  assign cfg_ready = both_empty;
  assign apply     = cfg_valid & both_empty;
  assign nxt       = cfg_dflt ? dflt_cfg(cfg_q, ch_en) : cfg_t'(cfg_byte);

  always_ff @(posedge clk) begin
    if (!rst_n)     cfg_q <= dflt_cfg('0, ch_en);
    else if (apply) cfg_q <= nxt;
  end

  always_comb begin
    case (cfg_q.split)
      2'b00:   share0 = LW'(DEPTH);
      2'b11:   share0 = '0;
      default: share0 = LW'(DEPTH / 2);
    endcase
    share1 = LW'(DEPTH) - share0;
    thr0   = LW'(thr_words(32'(share0), cfg_q.thr0));
    thr1   = LW'(thr_words(32'(share1), cfg_q.thr1));
  end

  // R6: the configuration stays put unless a request is taken
  a_r6_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !apply |=> $stable(cfg_q));

endmodule

// File: rtl/split_fifo_part.sv
module split_fifo_part #(
  parameter int DEPTH        = 16,
  parameter int SECTOR_WORDS = 128,
  parameter int LW           = $clog2(DEPTH + 1),
  parameter int AW           = $clog2(DEPTH),
  parameter int SW           = $clog2(SECTOR_WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [LW-1:0] share,
  input  logic [LW-1:0] thr,
  input  logic          push,
  input  logic          pop,
  input  logic          flush_in,
  input  logic          irq,
  input  logic          irq_en,
  input  logic          sec_en,
  output logic          wr_ready,
  output logic          rd_valid,
  output logic [LW-1:0] level,
  output logic [AW-1:0] wptr,
  output logic [AW-1:0] rptr,
  output logic          do_push,
  output logic          dma_req,
  output logic          dma_off,
  output logic          ovf,
  output logic          udf
);

  logic          full, empty, do_pop, flush_now, sec_hit;
  logic [SW-1:0] sec_cnt;

  function automatic logic [AW-1:0] adv(logic [AW-1:0] p, logic [LW-1:0] lim);
    return (LW'(p) + LW'(1) == lim) ? '0 : p + AW'(1);
  endfunction

  assign full      = (level == share);
  assign empty     = (level == '0);
  assign wr_ready  = !full;
  assign rd_valid  = !empty;
  assign do_push   = push & !full;
  assign do_pop    = pop & !empty;
  assign dma_off   = (share == '0);
  assign dma_req   = !dma_off && (level >= thr);
  assign flush_now = flush_in | (irq & irq_en) | (sec_hit & sec_en);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      level   <= '0;
      wptr    <= '0;
      rptr    <= '0;
      ovf     <= 1'b0;
      udf     <= 1'b0;
      sec_cnt <= '0;
      sec_hit <= 1'b0;
    end else if (flush_now) begin
      level   <= '0;
      wptr    <= '0;
      rptr    <= '0;
      sec_hit <= 1'b0;
    end else begin
      if (do_push) wptr <= adv(wptr, share);
      if (do_pop)  rptr <= adv(rptr, share);
      level   <= level + LW'(do_push) - LW'(do_pop);
      ovf     <= ovf | (push & full);
      udf     <= udf | (pop & empty);
      sec_hit <= do_push && (sec_cnt == SW'(SECTOR_WORDS - 1));
      if (do_push) sec_cnt <= (sec_cnt == SW'(SECTOR_WORDS - 1)) ? '0 : sec_cnt + SW'(1);
    end
  end

  a_r1_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    level <= share);

  a_r10_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush_in |=> (level == '0));

  a_r9_udf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    udf && !clr |=> udf);

  a_r8_drop_sets_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    push && full && !clr && !flush_now |=> ovf);

endmodule

// File: rtl/split_fifo_store.sv
module split_fifo_store #(
  parameter int DEPTH = 16,
  parameter int W     = 32,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic [1:0]      we,
  input  logic [2*AW-1:0] waddr,
  input  logic [2*W-1:0]  wdata,
  input  logic [2*AW-1:0] raddr,
  output logic [2*W-1:0]  rdata
);

  logic [W-1:0] mem [DEPTH];

  // The two partitions never overlap, so the two write ports never collide.
  always_ff @(posedge clk) begin
    for (int c = 0; c < 2; c++)
      if (we[c]) mem[waddr[c*AW +: AW]] <= wdata[c*W +: W];
  end

  for (genvar c = 0; c < 2; c++) begin : g_rd
    assign rdata[c*W +: W] = mem[raddr[c*AW +: AW]];
  end

endmodule

// File: rtl/split_fifo_dual.sv
module split_fifo_dual
  import split_fifo_pkg::*;
#(
  parameter int DEPTH        = 16,
  parameter int DATA_W       = 32,
  parameter int SECTOR_WORDS = 128,
  parameter int LW           = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      ch_en,
  input  logic            cfg_valid,
  input  logic            cfg_dflt,
  input  logic [7:0]      cfg_byte,
  output logic            cfg_ready,
  output logic [7:0]      cfg_q,
  input  logic [1:0]      wr_valid,
  input  logic [2*DATA_W-1:0] wr_data,
  output logic [1:0]      wr_ready,
  output logic [1:0]      rd_valid,
  input  logic [1:0]      rd_ready,
  output logic [2*DATA_W-1:0] rd_data,
  output logic [2*LW-1:0] level,
  output logic [1:0]      dma_req,
  output logic [1:0]      dma_off,
  input  logic [1:0]      flush,
  input  logic [1:0]      irq,
  input  logic [1:0]      irq_flush_en,
  input  logic [1:0]      sec_flush_en,
  output logic [1:0]      ovf,
  output logic [1:0]      udf
);

  localparam int AW = $clog2(DEPTH);

  cfg_t          cfg_s;
  logic          apply, both_empty;
  logic [LW-1:0] share [2];
  logic [LW-1:0] thr   [2];
  logic [LW-1:0] lvl   [2];
  logic [AW-1:0] wptr  [2];
  logic [AW-1:0] rptr  [2];
  logic [AW-1:0] base  [2];
  logic [1:0]    we;
  logic [2*AW-1:0]     waddr, raddr;
  logic [2*DATA_W-1:0] mem_q;

  assign both_empty = (lvl[0] == '0) && (lvl[1] == '0);
  assign cfg_q      = cfg_s;

  split_fifo_cfg #(.DEPTH(DEPTH), .LW(LW)) i_cfg (
    .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .cfg_valid(cfg_valid),
    .cfg_dflt(cfg_dflt), .cfg_byte(cfg_byte), .both_empty(both_empty),
    .cfg_ready(cfg_ready), .apply(apply), .cfg_q(cfg_s),
    .share0(share[0]), .share1(share[1]), .thr0(thr[0]), .thr1(thr[1])
  );

  assign base[0] = '0;
  assign base[1] = AW'(share[0]);

  for (genvar c = 0; c < 2; c++) begin : g_ch
    split_fifo_part #(.DEPTH(DEPTH), .SECTOR_WORDS(SECTOR_WORDS), .LW(LW)) i_part (
      .clk(clk), .rst_n(rst_n), .clr(apply), .share(share[c]), .thr(thr[c]),
      .push(wr_valid[c]), .pop(rd_ready[c]), .flush_in(flush[c]), .irq(irq[c]),
      .irq_en(irq_flush_en[c]), .sec_en(sec_flush_en[c]),
      .wr_ready(wr_ready[c]), .rd_valid(rd_valid[c]), .level(lvl[c]),
      .wptr(wptr[c]), .rptr(rptr[c]), .do_push(we[c]), .dma_req(dma_req[c]),
      .dma_off(dma_off[c]), .ovf(ovf[c]), .udf(udf[c])
    );
    assign waddr[c*AW +: AW]     = base[c] + wptr[c];
    assign raddr[c*AW +: AW]     = base[c] + rptr[c];
    assign level[c*LW +: LW]     = lvl[c];
    assign rd_data[c*DATA_W +: DATA_W] = rd_valid[c] ? mem_q[c*DATA_W +: DATA_W] : '0;

    // R3: a channel with no share accepts nothing and offers nothing
    a_r3_off_is_closed: assert property (@(posedge clk) disable iff (!rst_n)
      dma_off[c] |-> !wr_ready[c] && !rd_valid[c] && !dma_req[c]);
  end

  split_fifo_store #(.DEPTH(DEPTH), .W(DATA_W)) i_store (
    .clk(clk), .we(we), .waddr(waddr), .wdata(wr_data), .raddr(raddr), .rdata(mem_q)
  );

  // R6: the configuration only moves while both partitions were empty
  a_r6_change_only_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_q) |-> ($past(level) == '0));

endmodule

// File: tb/test_split_fifo_dual.sv
module test_split_fifo_dual;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [1:0]  ch_en = 2'b11;
  logic        cfg_valid = 0, cfg_dflt = 0;
  logic [7:0]  cfg_byte = 0;
  logic        cfg_ready;
  logic [7:0]  cfg_q;
  logic [1:0]  wr_valid = 0, rd_ready = 0, flush = 0, irq = 0;
  logic [1:0]  irq_flush_en = 0, sec_flush_en = 0;
  logic [63:0] wr_data = 0;
  logic [1:0]  wr_ready, rd_valid, dma_req, dma_off, ovf, udf;
  logic [63:0] rd_data;
  logic [9:0]  level;

  int total = 0, bad = 0;

  always #5 clk = ~clk;

  split_fifo_dual i_split_fifo_dual (
    .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .cfg_valid(cfg_valid), .cfg_dflt(cfg_dflt),
    .cfg_byte(cfg_byte), .cfg_ready(cfg_ready), .cfg_q(cfg_q), .wr_valid(wr_valid),
    .wr_data(wr_data), .wr_ready(wr_ready), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_data(rd_data), .level(level), .dma_req(dma_req), .dma_off(dma_off),
    .flush(flush), .irq(irq), .irq_flush_en(irq_flush_en), .sec_flush_en(sec_flush_en),
    .ovf(ovf), .udf(udf)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic int share_of(logic [7:0] b, int c);
    int s0;
    s0 = (b[6:5] == 2'b00) ? 16 : (b[6:5] == 2'b11) ? 0 : 8;
    return c == 0 ? s0 : 16 - s0;
  endfunction

  function automatic int thr_of(int share, logic [1:0] code);
    int t;
    t = share * (4 - int'(code)) / 4;
    return t < 1 ? 1 : t;
  endfunction

  function automatic logic [31:0] pat(int c, logic [7:0] b, int k);
    return {8'(c + 8'hC0), b, 16'(k)};
  endfunction

  function automatic int lv(int c);
    return int'(level[c*5 +: 5]);
  endfunction

  task automatic cycle();
    @(negedge clk);
  endtask

  task automatic apply_cfg(logic [7:0] b, logic d);
    cfg_byte = b; cfg_dflt = d; cfg_valid = 1;
    cycle();
    cfg_valid = 0; cfg_dflt = 0;
  endtask

  task automatic push(int c, logic [31:0] v);
    wr_valid[c] = 1; wr_data[c*32 +: 32] = v;
    cycle();
    wr_valid = 0;
  endtask

  task automatic pop(int c);
    rd_ready[c] = 1;
    cycle();
    rd_ready = 0;
  endtask

  task automatic sweep_one(logic [7:0] b);
    int s [2];
    int m;
    apply_cfg(b, 0);
    chk("R5 cfg_q", 32'(cfg_q), 32'(b));
    chk("R6 flags cleared", {28'd0, ovf, udf}, 32'd0);
    for (int c = 0; c < 2; c++) s[c] = share_of(b, c);
    for (int k = 0; k < 17; k++) begin
      wr_valid = 2'b11;
      wr_data = {pat(1, b, k), pat(0, b, k)};
      cycle();
      wr_valid = 0;
      for (int c = 0; c < 2; c++) begin
        m = (k + 1 < s[c]) ? k + 1 : s[c];
        chk("R1 level", 32'(lv(c)), 32'(m));
        chk("R1 wr_ready", 32'(wr_ready[c]), 32'(m < s[c]));
        chk("R3 dma_off", 32'(dma_off[c]), 32'(s[c] == 0));
        chk("R2 dma_req", 32'(dma_req[c]),
            32'(s[c] != 0 && m >= thr_of(s[c], c == 0 ? b[3:2] : b[1:0])));
      end
    end
    chk("R8 ovf", 32'(ovf), 32'd3);
    for (int j = 0; j < 17; j++) begin
      for (int c = 0; c < 2; c++) begin
        chk("R7 rd_valid", 32'(rd_valid[c]), 32'(j < s[c]));
        chk("R7 rd_data", rd_data[c*32 +: 32], (j < s[c]) ? pat(c, b, j) : 32'd0);
      end
      rd_ready = 2'b11;
      cycle();
      rd_ready = 0;
    end
    chk("R9 udf", 32'(udf), 32'd3);
    chk("R9 drained", 32'(level), 32'd0);
  endtask

  task automatic sector_run(logic en);
    sec_flush_en = {1'b0, en};
    for (int i = 0; i < 127; i++) begin
      push(0, 32'(i));
      pop(0);
    end
    push(0, 32'h5EC);
    chk("R12 level after 128th word", 32'(lv(0)), 32'd1);
    cycle();
    chk("R12 sector flush", 32'(lv(0)), en ? 32'd0 : 32'd1);
    if (!en) pop(0);
    sec_flush_en = 0;
  endtask

  initial begin
    logic [7:0] b;
    repeat (3) cycle();
    rst_n = 1;
    cycle();
    chk("R4 reset cfg", 32'(cfg_q), 32'h25);
    chk("R4 reset level", 32'(level), 32'd0);
    chk("R6 reset cfg_ready", 32'(cfg_ready), 32'd1);
    chk("R3 reset dma_off", 32'(dma_off), 32'd0);

    ch_en = 2'b01; apply_cfg(8'hFF, 1);
    chk("R4 dflt primary", 32'(cfg_q), 32'h05);
    chk("R4 dflt primary off", 32'(dma_off), 32'd2);
    ch_en = 2'b10; apply_cfg(8'h00, 1);
    chk("R4 dflt secondary", 32'(cfg_q), 32'h65);
    chk("R4 dflt secondary off", 32'(dma_off), 32'd1);
    apply_cfg(8'h90, 0);
    ch_en = 2'b11; apply_cfg(8'h00, 1);
    chk("R4 dflt keeps bits 7,4", 32'(cfg_q), 32'hB5);

    for (int sp = 0; sp < 4; sp++)
      for (int t0 = 0; t0 < 4; t0++)
        for (int t1 = 0; t1 < 4; t1++) begin
          b = {t1[0], 2'(sp), t0[1], 2'(t0), 2'(t1)};
          sweep_one(b);
        end

    apply_cfg(8'h25, 0);
    push(0, 32'hAB);
    chk("R6 busy", 32'(cfg_ready), 32'd0);
    apply_cfg(8'h00, 0);
    chk("R6 refused", 32'(cfg_q), 32'h25);
    pop(0);
    apply_cfg(8'h00, 0);
    chk("R6 taken", 32'(cfg_q), 32'h00);

    apply_cfg(8'h25, 0);
    push(0, 1); push(0, 2);
    push(1, 3); push(1, 4); push(1, 5);
    flush = 2'b10; cycle(); flush = 0;
    chk("R10 flushed", 32'(lv(1)), 32'd0);
    chk("R10 flushed rd_valid", 32'(rd_valid[1]), 32'd0);
    chk("R10 other untouched", 32'(lv(0)), 32'd2);
    irq = 2'b01; cycle(); irq = 0;
    chk("R11 irq disabled", 32'(lv(0)), 32'd2);
    chk("R11 data kept", rd_data[31:0], 32'd1);
    irq_flush_en = 2'b01; irq = 2'b01; cycle(); irq = 0; irq_flush_en = 0;
    chk("R11 irq flush", 32'(lv(0)), 32'd0);

    apply_cfg(8'h00, 0);
    sector_run(0);
    apply_cfg(8'h00, 0);
    sector_run(1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule